// File: doc/BRIEF.md
# Transmit Pad and FCS Inserter

This block sits on the transmit path between the frame buffer and the bit serializer and handles one frame at a time. Data bytes flow through combinationally, so a byte offered on the input with `out_ready` high reaches the output in the same cycle. When the final data byte has been handed over, the block decides how the frame will be finished. If padding is enabled and the frame is short, zero bytes are added until the payload reaches the minimum length. A four-byte frame check sequence follows unless the frame asked for none.

Two controls govern the tail. `pad_en` is looked at only on the cycle the end-of-frame byte is accepted, so moving it mid-frame affects only the next frame. `fcs_dis` is captured on that same accepted end-of-frame write and applies only to that frame. Enabling padding overrides `fcs_dis` and always adds the check sequence. While pad or check bytes are being sent, the input is held off.

Top module: `tx_pad_fcs_inserter`

## Requirements
- R1: After reset, with `in_valid` low, `out_valid` is low.
- R2: Each data byte accepted on the input (`in_valid && in_ready`) appears unchanged and in order on `out_data` in the same cycle. During the data phase `in_ready` equals `out_ready`.
- R3: If `pad_en` is 1 when the end-of-frame byte is accepted and the frame has fewer than 60 data bytes, bytes of value 00h follow the data until data plus pad total 60 bytes.
- R4: If `pad_en` is 0 at the end-of-frame byte, no pad byte is sent, and a frame shorter than 60 bytes leaves at its own length.
- R5: The check sequence is four bytes. It is the complement of the reflected CRC-32 (polynomial EDB88320h, start value FFFFFFFFh) over all data and pad bytes, sent least-significant byte first.
- R6: `fcs_dis` is taken only from the accepted end-of-frame byte. When it is 1 and padding is off, no check sequence is sent for that frame. Its value on earlier bytes has no effect.
- R7: When padding is enabled at the end-of-frame byte, the check sequence is sent whatever `fcs_dis` is.
- R8: `out_last` is 1 only on the frame's final output byte: the last check byte, or else the last pad or data byte.
- R9: While pad or check bytes are being sent, `in_ready` is 0.
- R10: While a pad or check byte is offered and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value into the next cycle.
- R11: A frame of 60 or more data bytes is never padded, whatever `pad_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken this cycle when valid |
| in_data | input | 8 | Input data byte |
| in_eof | input | 1 | Marks the frame's last data byte |
| pad_en | input | 1 | Enable short-frame padding, sampled at end of frame |
| fcs_dis | input | 1 | Suppress check sequence for this frame, captured at end of frame |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
Data bytes are due on the output in the same cycle they are accepted. The first pad or check byte is due in the cycle after the end-of-frame byte is accepted, and each later tail byte is due in the cycle after its predecessor is taken. The bench therefore compares every byte, and its last flag, against a queue built in advance from the requirements. It samples a few nanoseconds after the falling edge, when the inputs and the pseudo-random `out_ready` are settled, and counts a byte as transferred only when valid and ready are both high. Stall cycles are checked by comparing the held byte at the next sample point.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;

   typedef enum logic [1:0] {
      PH_DATA = 2'd0,
      PH_PAD  = 2'd1,
      PH_FCS  = 2'd2
   } phase_e;

   localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC32_SEED      = 32'hFFFF_FFFF;

endpackage

// File: rtl/tx_pad_fcs_crc.sv
module tx_pad_fcs_crc #(
   parameter int               CRC_W  = 32,
   parameter int               BYTE_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 32'hEDB8_8320,
   parameter logic [CRC_W-1:0] SEED   = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              clear,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [CRC_W-1:0]  crc_q
);

   initial begin
      assert (CRC_W > 0 && BYTE_W > 0)
         else $error("tx_pad_fcs_crc: widths must be positive");
   end

   // one shift stage per input bit, least significant bit first
   logic [CRC_W-1:0] chain [BYTE_W+1];
   assign chain[0] = crc_q;

   for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
      logic fb;
      assign fb = chain[g][0] ^ byte_in[g];
      assign chain[g+1] = fb ? ((chain[g] >> 1) ^ POLY) : (chain[g] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= SEED;
      else if (clear) crc_q <= SEED;
      else if (step)  crc_q <= chain[BYTE_W];
   end

endmodule

// File: rtl/tx_pad_fcs_ctrl.sv
module tx_pad_fcs_ctrl
   import tx_pad_fcs_pkg::*;
#(
   parameter int MIN_DATA_BYTES = 60,
   parameter int FCS_BYTES      = 4,
   parameter int IDX_W          = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_eof,
   input  logic             out_ready,
   input  logic             pad_en,
   input  logic             fcs_dis,
   output phase_e           phase,
   output logic             in_ready,
   output logic             out_valid,
   output logic             out_last,
   output logic [IDX_W-1:0] fcs_idx,
   output logic             crc_step,
   output logic             crc_clear
);

   localparam int CNT_W = $clog2(MIN_DATA_BYTES + 1);
   localparam logic [CNT_W-1:0] FILL_END = CNT_W'(MIN_DATA_BYTES - 1);
   localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(FCS_BYTES - 1);

   initial begin
      assert (MIN_DATA_BYTES >= 1)
         else $error("tx_pad_fcs_ctrl: MIN_DATA_BYTES must be at least 1");
      assert (FCS_BYTES >= 1 && (1 << IDX_W) >= FCS_BYTES)
         else $error("tx_pad_fcs_ctrl: IDX_W too narrow for FCS_BYTES");
   end

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic             fcs_on_q;

   logic short_frame, need_pad, need_fcs, in_fire, out_fire;

   assign phase       = phase_q;
   assign fcs_idx     = idx_q;
   assign short_frame = (cnt_q < FILL_END);
   assign need_pad    = pad_en && short_frame;
   assign need_fcs    = pad_en || !fcs_dis;

   always_comb begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_last  = 1'b0;
      unique case (phase_q)
         PH_DATA: begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_last  = in_eof && !need_pad && !need_fcs;
         end
         PH_PAD: begin
            out_valid = 1'b1;
            out_last  = !fcs_on_q && (cnt_q == FILL_END);
         end
         PH_FCS: begin
            out_valid = 1'b1;
            out_last  = (idx_q == IDX_END);
         end
         default: ;
      endcase
   end

   assign in_fire   = (phase_q == PH_DATA) && in_valid && out_ready;
   assign out_fire  = out_valid && out_ready;
   assign crc_step  = out_fire && (phase_q != PH_FCS);
   assign crc_clear = out_fire && out_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_DATA;
         cnt_q    <= '0;
         idx_q    <= '0;
         fcs_on_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_DATA: if (in_fire) begin
               if (in_eof) begin
                  fcs_on_q <= need_fcs;
                  idx_q    <= '0;
                  if (need_pad) begin
                     cnt_q   <= cnt_q + 1'b1;
                     phase_q <= PH_PAD;
                  end else begin
                     cnt_q   <= '0;
                     phase_q <= need_fcs ? PH_FCS : PH_DATA;
                  end
               end else if (cnt_q != FILL_END) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_PAD: if (out_fire) begin
               if (cnt_q == FILL_END) begin
                  cnt_q   <= '0;
                  phase_q <= fcs_on_q ? PH_FCS : PH_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_FCS: if (out_fire) begin
               if (idx_q == IDX_END) phase_q <= PH_DATA;
               else                  idx_q   <= idx_q + 1'b1;
            end
            default: phase_q <= PH_DATA;
         endcase
      end
   end

   // R3: the fill counter never runs past the minimum payload length
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FILL_END);

   // R7: padding is only ever entered with the check sequence armed
   p_pad_forces_fcs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PAD) |-> fcs_on_q);

   // R7: the last pad byte hands over to the check sequence
   p_pad_to_fcs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PAD && out_fire && cnt_q == FILL_END) |=> (phase_q == PH_FCS));

   // R8: after the final byte the block is back at the start of a frame
   p_last_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && out_last) |=> (phase_q == PH_DATA && cnt_q == '0));

   // R11: a full-length frame never enters the pad phase
   p_long_no_pad_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && in_eof && cnt_q == FILL_END) |=> (phase_q != PH_PAD));

endmodule

// File: rtl/tx_pad_fcs_inserter.sv
module tx_pad_fcs_inserter
   import tx_pad_fcs_pkg::*;
#(
   parameter int          BYTE_W         = 8,
   parameter int          MIN_DATA_BYTES = 60,
   parameter int          FCS_BYTES      = 4,
   parameter bit          FCS_LSB_FIRST  = 1'b1,
   parameter logic [7:0]  PAD_VALUE      = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_eof,
   input  logic              pad_en,
   input  logic              fcs_dis,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_last
);

   localparam int CRC_W = BYTE_W * FCS_BYTES;
   localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

   initial begin
      assert (CRC_W == 32)
         else $error("tx_pad_fcs_inserter: check sequence must total 32 bits");
      assert (BYTE_W == 8)
         else $error("tx_pad_fcs_inserter: byte stream must be 8 bits wide");
   end

   phase_e           phase;
   logic [IDX_W-1:0] fcs_idx;
   logic             crc_step, crc_clear;
   logic [CRC_W-1:0] crc_q, fcs_word;
   logic [BYTE_W-1:0] fcs_byte;

   tx_pad_fcs_ctrl #(
      .MIN_DATA_BYTES (MIN_DATA_BYTES),
      .FCS_BYTES      (FCS_BYTES),
      .IDX_W          (IDX_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_eof    (in_eof),
      .out_ready (out_ready),
      .pad_en    (pad_en),
      .fcs_dis   (fcs_dis),
      .phase     (phase),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_last  (out_last),
      .fcs_idx   (fcs_idx),
      .crc_step  (crc_step),
      .crc_clear (crc_clear)
   );

   tx_pad_fcs_crc #(
      .CRC_W  (CRC_W),
      .BYTE_W (BYTE_W),
      .POLY   (CRC_W'(CRC32_POLY_REFL)),
      .SEED   (CRC_W'(CRC32_SEED))
   ) crc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (crc_step),
      .clear   (crc_clear),
      .byte_in (out_data),
      .crc_q   (crc_q)
   );

   assign fcs_word = ~crc_q;

   if (FCS_LSB_FIRST) begin : g_lsb_first
      assign fcs_byte = fcs_word[fcs_idx*BYTE_W +: BYTE_W];
   end else begin : g_msb_first
      logic [IDX_W-1:0] rev_idx;
      assign rev_idx  = IDX_W'(FCS_BYTES - 1) - fcs_idx;
      assign fcs_byte = fcs_word[rev_idx*BYTE_W +: BYTE_W];
   end

   always_comb begin
      unique case (phase)
         PH_PAD:  out_data = BYTE_W'(PAD_VALUE);
         PH_FCS:  out_data = fcs_byte;
         default: out_data = in_data;
      endcase
   end

   // R10: a stalled tail byte stays offered and unchanged
   p_tail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && phase != PH_DATA) |=> (out_valid && $stable(out_data)));

   // R9: no input byte is taken while the tail is being sent
   p_tail_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last && phase != PH_DATA) |=> !in_ready);

endmodule

// File: tb/tx_pad_fcs_inserter_tb_top.sv
module tx_pad_fcs_inserter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_eof = 1'b0;
   logic       pad_en = 1'b0;
   logic       fcs_dis = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic       out_last;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;
   bit bp_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [7:0] exp_data [$];
   bit         exp_last [$];
   int         exp_kind [$];
   string      exp_tag  [$];
   string      last_tag [$];

   always #5 clk = ~clk;

   tx_pad_fcs_inserter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_eof    (in_eof),
      .pad_en    (pad_en),
      .fcs_dis   (fcs_dis),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   function automatic logic [31:0] crc_add(logic [31:0] c, logic [7:0] b);
      logic [31:0] r = c ^ {24'h0, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // pseudo-random downstream back-pressure
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= bp_on ? (lfsr[1:0] != 2'b00) : 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   // output monitor
   bit         prev_stall = 1'b0;
   logic [7:0] prev_data = 8'h00;
   int         prev_kind = 0;
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (prev_stall && prev_kind != 0) begin
            // R10
            check(out_valid === 1'b1 && out_data === prev_data, "R10",
                  "stalled tail byte not held", out_data, prev_data);
         end
         prev_stall = 1'b0;
         if (out_valid && out_ready) begin
            if (exp_data.size() == 0) begin
               check(1'b0, "R2", "unexpected output byte", out_data, 0);
            end else begin
               check(out_data === exp_data[0], exp_tag[0], "output byte", out_data, exp_data[0]);
               check(out_last === exp_last[0], last_tag[0], "last flag (R8)", out_last, exp_last[0]);
               if (exp_kind[0] != 0)
                  check(in_ready === 1'b0, "R9", "input ready during tail", in_ready, 0);
               void'(exp_data.pop_front());
               void'(exp_last.pop_front());
               void'(exp_kind.pop_front());
               void'(exp_tag.pop_front());
               void'(last_tag.pop_front());
            end
         end else if (out_valid && exp_data.size() != 0) begin
            prev_stall = 1'b1;
            prev_data  = out_data;
            prev_kind  = exp_kind[0];
         end
      end
   end

   task automatic send_frame(int len, bit pe, bit fd, int seed);
      logic [7:0]  bytes [$];
      logic [31:0] crc = 32'hFFFFFFFF;
      int          total;
      bit          fcs_on = pe || !fd;
      int          pad_n = (pe && len < 60) ? 60 - len : 0;
      string       lt;
      if (fcs_on)              lt = (pe && fd) ? "R7" : "R5";
      else if (len < 60 && !pe) lt = "R4";
      else                     lt = "R6";
      if (len >= 60 && pe)     lt = "R11";
      total = len + pad_n + (fcs_on ? 4 : 0);
      for (int i = 0; i < len; i++) bytes.push_back(8'((len * 7 + i * 13 + seed) & 8'hFF));
      for (int i = 0; i < len; i++) begin
         crc = crc_add(crc, bytes[i]);
         exp_data.push_back(bytes[i]); exp_kind.push_back(0);
         exp_tag.push_back(pe ? "R2" : (len < 60 ? "R4" : "R2"));
      end
      for (int i = 0; i < pad_n; i++) begin
         crc = crc_add(crc, 8'h00);
         exp_data.push_back(8'h00); exp_kind.push_back(1);
         exp_tag.push_back("R3");
      end
      if (fcs_on) begin
         for (int i = 0; i < 4; i++) begin
            exp_data.push_back(8'((~crc) >> (8 * i))); exp_kind.push_back(2);
            exp_tag.push_back(fd ? "R7" : "R5");
         end
      end
      for (int i = 0; i < total; i++) begin
         exp_last.push_back(i == total - 1);
         last_tag.push_back(lt);
      end
      for (int i = 0; i < len; i++) begin
         bit acc;
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = bytes[i];
         in_eof   = (i == len - 1);
         pad_en   = in_eof ? pe : ~pe;
         fcs_dis  = in_eof ? fd : ~fd;
         forever begin
            #1 acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_eof   = 1'b0;
   endtask

   initial begin
      // bench CRC sanity: standard check value of the ASCII digits 1..9 (R5)
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < 9; i++) c = crc_add(c, 8'h31 + 8'(i));
      check(~c == 32'hCBF43926, "R5", "bench crc reference", ~c, 32'hCBF43926);

      repeat (3) @(posedge clk);
      @(negedge clk);
      #2 check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #2 check(out_valid === 1'b0, "R1", "out_valid idle", out_valid, 0);

      // sweep: every length 1..64, every pad/fcs setting, with and without back-pressure
      for (int bp = 0; bp < 2; bp++) begin
         bp_on = bp[0];
         for (int len = 1; len <= 64; len++) begin
            for (int mode = 0; mode < 4; mode++) begin
               send_frame(len, mode[1], mode[0], bp * 31 + mode);
            end
         end
      end
      // back-to-back frames straddling the minimum length
      for (int len = 58; len <= 61; len++) send_frame(len, 1'b1, 1'b1, 99);

      wait (exp_data.size() == 0);
      repeat (4) @(negedge clk);
      #2 check(out_valid === 1'b0, "R2", "no stray output after last frame", out_valid, 0);
      done = 1'b1;
      finish_run();
   end

endmodule